// File: doc/BRIEF.md
# Program Fetch Cache with Clear, Enable and Freeze Control

This block sits between a processor's instruction-fetch port and external program memory. It holds a small number of segments, each covering 32 consecutive words aligned on a 32-word boundary. Each segment carries one address tag and one valid bit per word. A rank per segment keeps the least-recently-used order across segments. A program fetch that finds a valid copy is answered from the cache one cycle after acceptance. Any other fetch goes to memory through a request/ready handshake, and the returned word may be written into the cache.

Data reads, data writes and program fetches into the internal address region (word addresses below `INT_WORDS`) always go straight to memory and leave the cache state alone. Three control bits govern caching. Clear is a one-shot invalidate of every word. Enable switches lookups and updates on or off. Freeze keeps hits working but locks the contents and the LRU order. The cache is not kept coherent with memory writes. A write to a cached address leaves the old instruction in the cache.

Top module: `prog_fetch_cache`

## Requirements
- R1: After reset the status reads 0 (bit 0 clear, bit 1 enable, bit 2 freeze), `req_ready` is 1, `rsp_valid` is 0, and every word is invalid, so the first cacheable fetch misses.
- R2: A request with `req_prog`=0 (data read, or data write when `req_we`=1) goes to memory and responds with `rsp_hit`=0 and `rsp_miss`=0. It leaves tags, valid bits and LRU order unchanged.
- R3: A program fetch whose word address is below `INT_WORDS` goes to memory with `rsp_hit`=0 and `rsp_miss`=0 and is never filled.
- R4: With enable=1, a program fetch to a valid cached word responds with `rsp_hit`=1 and the cached data in the cycle after acceptance, without a memory request.
- R5: A cacheable miss whose tag (address bits above the low 5) matches a segment fills only that word, marks it valid and sets `rsp_miss`=1. Other words of that segment stay invalid.
- R6: A cacheable miss whose tag matches no segment reallocates the least-recently-used segment: new tag, all valid bits cleared, and only the fetched word valid.
- R7: When not frozen, every hit and every fill makes the segment concerned the most recently used.
- R8: Writing 1 to bit 0 of `ctl_wdata` invalidates every word, whatever the enable and freeze values written or held. Status bit 0 always reads 0.
- R9: With enable=0, program fetches get no hit, no miss flag and no fill. Both flags are 0 and the data comes from memory.
- R10: With enable=1 and freeze=1, hits are served, misses report `rsp_miss`=1 but fill nothing, and the LRU order does not change.
- R11: A data write to an address that is cached does not alter or invalidate the cached word. A later hit returns the old value.
- R12: `mem_req` stays high with stable `mem_addr` and `mem_we` until a cycle with `mem_ready`=1 completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 3 | Control write value: bit0 clear, bit1 enable, bit2 freeze |
| ctl_status | output | 3 | Control readback, same layout, bit0 always 0 |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_prog | input | 1 | 1 = program fetch, 0 = data access |
| req_we | input | 1 | Data write when `req_prog`=0 |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DW | Read data of the response |
| rsp_hit | output | 1 | Response served from the cache |
| rsp_miss | output | 1 | Cacheable enabled fetch that was not in the cache |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the request this cycle |

## Verification
A corrupted valid bit or tag shows on the very next fetch to that address. The hit flag, the miss flag and the one-cycle hit latency disagree with the expected values, and a lost fill appears as a second miss. A wrong LRU rank does not show at once. It appears only at the next reallocation, when the wrong segment is evicted and a later fetch to the survivor misses. Stale copies after data writes and updates made while frozen are exposed by returning data that differs from current memory.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } pfc_state_e;

    // Bit positions shared by ctl_wdata and ctl_status
    localparam int CTL_CLR = 0;
    localparam int CTL_ENA = 1;
    localparam int CTL_FRZ = 2;

endpackage

// File: rtl/pfc_ctrl_bits.sv
module pfc_ctrl_bits
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output logic       ena,
    output logic       frz,
    output logic       clr_pulse,
    output logic [2:0] status
);

    typedef struct packed {
        logic ena;
        logic frz;
    } ctl_t;

    ctl_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.ena = wr_data[CTL_ENA];
            d.frz = wr_data[CTL_FRZ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Clear acts for the single write cycle only; nothing stores it
    assign clr_pulse = wr_en & wr_data[CTL_CLR];
    assign ena       = q.ena;
    assign frz       = q.frz;

    always_comb begin
        status          = '0;
        status[CTL_ENA] = q.ena;
        status[CTL_FRZ] = q.frz;
    end

endmodule

// File: rtl/pfc_tag_lru.sv
module pfc_tag_lru #(
    parameter int TAG_W = 5,
    parameter int OFF_W = 5,
    parameter int NSEG  = 2,
    parameter int SEG_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [OFF_W-1:0] lk_off,
    output logic             hit,
    output logic             match,
    output logic [SEG_W-1:0] match_seg,
    output logic [SEG_W-1:0] victim_seg,
    input  logic             clr,
    input  logic             touch_en,
    input  logic [SEG_W-1:0] touch_seg,
    input  logic             fill_en,
    input  logic             alloc_en,
    input  logic [SEG_W-1:0] fill_seg,
    input  logic [OFF_W-1:0] fill_off,
    input  logic [TAG_W-1:0] alloc_tag
);

    localparam int WORDS = 1 << OFF_W;

    typedef struct packed {
        logic [NSEG-1:0][TAG_W-1:0] tag;
        logic [NSEG-1:0][WORDS-1:0] vld;
        logic [NSEG-1:0][SEG_W-1:0] rank;
    } tstate_t;

    tstate_t d, q;

    // Lookup: lowest matching segment wins; victim holds the oldest rank
    always_comb begin
        match      = 1'b0;
        match_seg  = '0;
        victim_seg = '0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (q.tag[s] == lk_tag) begin
                match     = 1'b1;
                match_seg = SEG_W'(s);
            end
            if (q.rank[s] == SEG_W'(NSEG - 1)) victim_seg = SEG_W'(s);
        end
        hit = match && q.vld[match_seg][lk_off];
    end

    always_comb begin
        d = q;
        if (fill_en) begin
            if (alloc_en) begin
                d.tag[fill_seg] = alloc_tag;
                d.vld[fill_seg] = '0;
            end
            d.vld[fill_seg][fill_off] = 1'b1;
        end
        if (touch_en) begin
            for (int s = 0; s < NSEG; s++) begin
                if (q.rank[s] < q.rank[touch_seg]) d.rank[s] = q.rank[s] + 1'b1;
            end
            d.rank[touch_seg] = '0;
        end
        if (clr) d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.tag <= '0;
            q.vld <= '0;
            for (int s = 0; s < NSEG; s++) q.rank[s] <= SEG_W'(s);
        end else begin
            q <= d;
        end
    end

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.vld == '0));

    // R7
    touched_is_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (q.rank[$past(touch_seg)] == '0));

    // R6
    alloc_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && alloc_en && !clr) |=> ($countones(q.vld[$past(fill_seg)]) == 1));

endmodule

// File: rtl/pfc_data_ram.sv
module pfc_data_ram #(
    parameter int DW    = 32,
    parameter int OFF_W = 5,
    parameter int NSEG  = 2,
    parameter int SEG_W = 1
) (
    input  logic             clk,
    input  logic [SEG_W-1:0] rd_seg,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data
);

    localparam int WORDS = 1 << OFF_W;

    logic [DW-1:0] ram_q [NSEG][WORDS];

    assign rd_data = ram_q[rd_seg][rd_off];

    always_ff @(posedge clk) begin
        if (wr_en) ram_q[wr_seg][wr_off] <= wr_data;
    end

endmodule

// File: rtl/prog_fetch_cache.sv
module prog_fetch_cache
    import pfc_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 32,
    parameter int OFF_W     = 5,
    parameter int NSEG      = 2,
    parameter int INT_WORDS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [2:0]    ctl_wdata,
    output logic [2:0]    ctl_status,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_prog,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_hit,
    output logic          rsp_miss,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    localparam int            TAG_W   = AW - OFF_W;
    localparam int            SEG_W   = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam logic [AW-1:0] INT_LIM = AW'(INT_WORDS);

    typedef struct packed {
        pfc_state_e    st;
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] wdata;
        logic          look;
        logic          rv;
        logic [DW-1:0] rdat;
        logic          rhit;
        logic          rmiss;
    } top_t;

    top_t d, q;

    logic             ena, frz, clr_pulse;
    logic [AW-1:0]    lk_addr;
    logic             hit, match;
    logic [SEG_W-1:0] match_seg, victim_seg;
    logic             touch_en, fill_en, alloc_en;
    logic [SEG_W-1:0] touch_seg, fill_seg;
    logic [DW-1:0]    ram_rd;
    logic             cacheable, lookup, accept, done;

    pfc_ctrl_bits u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_we),
        .wr_data   (ctl_wdata),
        .ena       (ena),
        .frz       (frz),
        .clr_pulse (clr_pulse),
        .status    (ctl_status)
    );

    // Idle: look up the incoming address; busy: the held miss address
    assign lk_addr = (q.st == ST_IDLE) ? req_addr : q.addr;

    pfc_tag_lru #(.TAG_W(TAG_W), .OFF_W(OFF_W), .NSEG(NSEG), .SEG_W(SEG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_addr[AW-1:OFF_W]),
        .lk_off     (lk_addr[OFF_W-1:0]),
        .hit        (hit),
        .match      (match),
        .match_seg  (match_seg),
        .victim_seg (victim_seg),
        .clr        (clr_pulse),
        .touch_en   (touch_en),
        .touch_seg  (touch_seg),
        .fill_en    (fill_en),
        .alloc_en   (alloc_en),
        .fill_seg   (fill_seg),
        .fill_off   (q.addr[OFF_W-1:0]),
        .alloc_tag  (q.addr[AW-1:OFF_W])
    );

    pfc_data_ram #(.DW(DW), .OFF_W(OFF_W), .NSEG(NSEG), .SEG_W(SEG_W)) u_ram (
        .clk     (clk),
        .rd_seg  (match_seg),
        .rd_off  (req_addr[OFF_W-1:0]),
        .rd_data (ram_rd),
        .wr_en   (fill_en),
        .wr_seg  (fill_seg),
        .wr_off  (q.addr[OFF_W-1:0]),
        .wr_data (mem_rdata)
    );

    assign cacheable = req_prog && (req_addr >= INT_LIM);
    assign lookup    = cacheable && ena;
    assign accept    = req_valid && (q.st == ST_IDLE);
    assign done      = (q.st == ST_MEM) && mem_ready;

    always_comb begin
        d         = q;
        d.rv      = 1'b0;
        touch_en  = 1'b0;
        touch_seg = match_seg;
        fill_en   = 1'b0;
        alloc_en  = 1'b0;
        fill_seg  = match_seg;

        if (accept) begin
            if (lookup && hit) begin
                d.rv     = 1'b1;
                d.rdat   = ram_rd;
                d.rhit   = 1'b1;
                d.rmiss  = 1'b0;
                touch_en = !frz;
            end else begin
                d.st    = ST_MEM;
                d.addr  = req_addr;
                d.we    = req_we && !req_prog;
                d.wdata = req_wdata;
                d.look  = lookup;
            end
        end

        if (done) begin
            d.st    = ST_IDLE;
            d.rv    = 1'b1;
            d.rdat  = mem_rdata;
            d.rhit  = 1'b0;
            d.rmiss = q.look;
            if (q.look && ena && !frz) begin
                fill_en   = 1'b1;
                alloc_en  = !match;
                fill_seg  = match ? match_seg : victim_seg;
                touch_en  = 1'b1;
                touch_seg = fill_seg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rv;
    assign rsp_rdata = q.rdat;
    assign rsp_hit   = q.rv && q.rhit;
    assign rsp_miss  = q.rv && q.rmiss;
    assign mem_req   = (q.st == ST_MEM);
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_miss));

    // R9
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !ena) |=> !rsp_hit);

    // R2
    data_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we) |=> (rsp_valid && !rsp_hit && !rsp_miss));

endmodule

// File: tb/prog_fetch_cache_tb_top.sv
module prog_fetch_cache_tb_top;

    localparam int AW   = 10;
    localparam int DW   = 32;
    localparam int INTW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [2:0]    ctl_wdata = '0;
    logic [2:0]    ctl_status;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_prog = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_hit, rsp_miss;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    prog_fetch_cache #(.AW(AW), .DW(DW), .OFF_W(5), .NSEG(2), .INT_WORDS(INTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_status(ctl_status), .req_valid(req_valid), .req_ready(req_ready),
        .req_prog(req_prog), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Reference state
    logic [DW-1:0] mem [1024];
    int            m_tag [2];
    bit            m_vld [2][32];
    logic [DW-1:0] m_dat [2][32];
    int            m_lru;
    bit            m_ena, m_frz;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 32; w++) m_vld[s][w] = 0;
    endfunction

    task automatic ctl_write(input bit c, input bit e, input bit f, input string rq);
        ctl_we    = 1'b1;
        ctl_wdata = {f, e, c};
        @(posedge clk);
        @(negedge clk);
        ctl_we = 1'b0;
        if (c) model_clear();
        m_ena = e;
        m_frz = f;
        chk(ctl_status == {f, e, 1'b0}, rq, "status readback", ctl_status, {f, e, 1'b0});
    endtask

    // One request; expected results come from the reference state
    task automatic xfer(input bit prog, input bit we, input int addr,
                        input logic [DW-1:0] wd, input string rq);
        bit   cach, look, ehit, emiss, match, mem_seen, addr_bad;
        int   tag, off, ms, n, dly, fs;
        logic [DW-1:0] edat;
        tag = addr >> 5;
        off = addr & 31;
        cach = prog && (addr >= INTW);
        look = cach && m_ena;
        match = 0; ms = 0;
        for (int s = 1; s >= 0; s--) if (m_tag[s] == tag) begin match = 1; ms = s; end
        ehit  = look && match && m_vld[ms][off];
        emiss = look && !ehit;
        edat  = ehit ? m_dat[ms][off] : mem[addr];
        dly   = $urandom % 4;

        req_valid = 1'b1; req_prog = prog; req_we = we;
        req_addr = AW'(addr); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; mem_seen = 0; addr_bad = 0;
        forever begin
            if (rsp_valid) break;
            mem_ready = 1'b0;
            if (mem_req) begin
                mem_seen = 1;
                if (mem_addr != AW'(addr) || mem_we != (we && !prog)) addr_bad = 1;
                if (dly == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem[addr];
                end else dly--;
            end
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n > 40) break;
        end
        mem_ready = 1'b0;

        chk(rsp_valid, rq, "response arrived", rsp_valid, 1);
        chk(rsp_hit == ehit, rq, "hit flag", rsp_hit, ehit);
        chk(rsp_miss == emiss, rq, "miss flag", rsp_miss, emiss);
        if (!(we && !prog)) chk(rsp_rdata == edat, rq, "read data", rsp_rdata, edat);
        if (ehit) begin
            chk(n == 1 && !mem_seen, rq, "R4 hit latency / no memory access", n, 1);
        end else begin
            chk(mem_seen && !addr_bad, rq, "R12 memory request held", addr_bad, 0);
        end

        // Reference update
        if (we && !prog) mem[addr] = wd;
        if (look && !m_frz) begin
            if (ehit) begin
                m_lru = 1 - ms;
            end else begin
                fs = match ? ms : m_lru;
                if (!match) begin
                    m_tag[fs] = tag;
                    for (int w = 0; w < 32; w++) m_vld[fs][w] = 0;
                end
                m_vld[fs][off] = 1;
                m_dat[fs][off] = mem[addr];
                m_lru = 1 - fs;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int a = 0; a < 1024; a++) mem[a] = (a * 32'h9E3779B1) ^ 32'h5A5A0000;
        m_tag[0] = 0; m_tag[1] = 0; m_lru = 1; m_ena = 0; m_frz = 0;
        model_clear();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_status == 3'b000, "R1", "status after reset", ctl_status, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

        ctl_write(0, 1, 0, "R8");
        xfer(1, 0, 10'h100, 0, "R1");
        xfer(1, 0, 10'h100, 0, "R4");
        xfer(1, 0, 10'h101, 0, "R5");
        xfer(1, 0, 10'h102, 0, "R5");
        xfer(1, 0, 10'h101, 0, "R5");
        xfer(1, 0, 10'h140, 0, "R6");
        xfer(1, 0, 10'h100, 0, "R7");
        xfer(1, 0, 10'h180, 0, "R6");
        xfer(1, 0, 10'h140, 0, "R7");
        xfer(1, 0, 10'h140, 0, "R6");
        xfer(1, 0, 10'h141, 0, "R6");

        // Stale copy after data write; data traffic bypasses
        xfer(0, 1, 10'h140, 32'hDEAD_BEEF, "R11");
        xfer(1, 0, 10'h140, 0, "R11");
        xfer(0, 0, 10'h140, 0, "R2");
        xfer(0, 0, 10'h1C0, 0, "R2");
        xfer(1, 0, 10'h140, 0, "R2");

        // Internal region
        xfer(1, 0, 5, 0, "R3");
        xfer(1, 0, 5, 0, "R3");
        xfer(1, 0, 63, 0, "R3");

        // Freeze
        ctl_write(0, 1, 1, "R10");
        xfer(1, 0, 10'h140, 0, "R10");
        xfer(1, 0, 10'h1E0, 0, "R10");
        xfer(1, 0, 10'h1E0, 0, "R10");
        xfer(1, 0, 10'h142, 0, "R10");
        xfer(1, 0, 10'h142, 0, "R10");

        // Clear while frozen, then while disabled
        ctl_write(1, 1, 1, "R8");
        xfer(1, 0, 10'h140, 0, "R8");
        ctl_write(0, 1, 0, "R8");
        xfer(1, 0, 10'h140, 0, "R8");
        xfer(1, 0, 10'h140, 0, "R4");
        ctl_write(0, 0, 0, "R9");
        xfer(1, 0, 10'h140, 0, "R9");
        xfer(1, 0, 10'h150, 0, "R9");
        ctl_write(1, 0, 0, "R8");
        ctl_write(0, 1, 0, "R8");
        xfer(1, 0, 10'h140, 0, "R8");
        xfer(1, 0, 10'h150, 0, "R9");

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int r, a;
            r = $urandom % 100;
            a = ((2 + $urandom % 4) << 5) | ($urandom % 8);
            if (r < 65)      xfer(1, 0, a, 0, "R4");
            else if (r < 73) xfer(0, 0, a, 0, "R2");
            else if (r < 81) xfer(0, 1, a, $urandom, "R11");
            else if (r < 87) xfer(1, 0, $urandom % INTW, 0, "R3");
            else begin
                bit c, e, f;
                c = ($urandom % 8) == 0;
                e = ($urandom % 8) != 0;
                f = ($urandom % 5) == 0;
                ctl_write(c, e, f, "R8");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule